// File: doc/BRIEF.md
# I2C Byte and Acknowledge Shift Engine

This block moves one I2C byte and its acknowledge bit. A 9-bit transmit word is loaded while the bus is idle and SCL is low. Its low eight bits go out most significant bit first on the first eight SCL clocks, and bit 8 goes out on the ninth clock as the acknowledge. SDA is open-drain. A 1 releases the line and a 0 pulls it low. The block never drives SDA high.

On every SCL rising edge the block samples the wired SDA level. It assembles a 9-bit receive word, which is published one system clock after the ninth rising edge, together with a single-cycle done pulse. To receive a byte, load all ones into bits 7..0 and put the acknowledge choice in bit 8: 0 for ACK, 1 for NACK. The surrounding controller makes that choice. A master gives NACK after its last byte, a slave gives NACK on an address mismatch, and every other case gets ACK.

Two layouts exist for the receive word, picked by a layout input. A phase input forces the standard layout back on.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `sda_oe`, `done` and `busy` are 0 and `rx_word` is 0.
- R2: `load` is accepted only while `busy` is 0. A `load` while `busy` is 1 has no effect on the bits sent or on the received word.
- R3: For the first eight SCL clocks, transmit bits 7..0 are presented most significant first. A 1 gives `sda_oe`=0 (released) and a 0 gives `sda_oe`=1 (pulled low). The first bit appears on the clock after the accepted load, and each later bit appears on the clock after the previous SCL falling edge.
- R4: On the ninth SCL clock, `sda_oe` is the inverse of transmit bit 8 (0 drives ACK low, 1 leaves NACK released). After the ninth SCL falling edge, `sda_oe` returns to 0.
- R5: `sda_oe` changes only while SCL is low. A `load` must therefore be presented with SCL low.
- R6: SDA is sampled once per SCL rising edge. With `alt_map`=0, the eight data bits land in `rx_word[7:0]` (first received bit in bit 7) and the ninth sampled bit lands in `rx_word[8]`.
- R7: With `alt_map`=1 and `phase_sel`=0, the first seven data bits land in `rx_word[6:0]` (first in bit 6), the eighth data bit lands in `rx_word[8]`, and the ninth sampled bit lands in `rx_word[7]`.
- R8: With `phase_sel`=1, the R6 layout is used whatever the value of `alt_map`. Both inputs are read at the ninth rising edge.
- R9: `done` is high for exactly one system clock, on the clock after the ninth SCL rising edge. `busy` falls at the same time, and `rx_word` updates then and holds until the next `done`.
- R10: Loading 0x0FF or 0x1FF keeps SDA released for all eight data clocks, so a peer's byte is received unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level, already synchronous to clk |
| sda_in | input | 1 | Wired SDA level, already synchronous to clk |
| load | input | 1 | Start a transfer with `tx_word` |
| tx_word | input | 9 | Bits 7..0 data, bit 8 acknowledge |
| alt_map | input | 1 | Selects the alternate receive layout |
| phase_sel | input | 1 | Forces the standard receive layout |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the ninth rising edge |
| rx_word | output | 9 | Received word in the selected layout |

## Verification
The engine is tried as a transmitter (data from the load word with the peer silent), as a receiver (0x0FF or 0x1FF loaded with the peer supplying the byte), and as both at once, where the bus carries the AND of the two.

Transmit runs show that bit order and the SDA level on each clock come from the load word alone. Receive runs with asymmetric bytes such as 0x01 and 0x80 make each layout (standard, alternate, and alternate with the phase override) produce a distinct word, so a swapped field or an ignored override shows up. A load presented in the middle of a transfer with an inverted word shows whether a busy engine really ignores it.

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       load,
  input  logic [8:0] tx_word,
  input  logic       alt_map,
  input  logic       phase_sel,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic [8:0] rx_word
);

  localparam logic [3:0] LAST = 4'd8;

  logic       scl_q;
  logic [3:0] cnt;
  logic [8:0] txr;
  logic [8:0] rxs;

  wire rise = scl_in & ~scl_q;
  wire fall = ~scl_in & scl_q;

  wire [8:0] nxt     = {rxs[7:0], sda_in};
  wire       cur_bit = (cnt == LAST) ? txr[8] : txr[3'd7 - cnt[2:0]];
  wire       use_alt = alt_map & ~phase_sel;
  wire [8:0] mapped  = use_alt ? {nxt[1], nxt[0], nxt[8:2]} : {nxt[0], nxt[8:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b0;
      cnt     <= '0;
      txr     <= '0;
      rxs     <= '0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      scl_q <= scl_in;
      done  <= 1'b0;
      if (!busy && load) begin
        busy   <= 1'b1;
        cnt    <= '0;
        txr    <= tx_word;
        sda_oe <= ~tx_word[7];
      end else if (busy && rise) begin
        rxs <= nxt;
        if (cnt == LAST) begin
          busy    <= 1'b0;
          cnt     <= '0;
          done    <= 1'b1;
          rx_word <= mapped;
        end else begin
          cnt <= cnt + 4'd1;
        end
      end else if (fall) begin
        sda_oe <= busy ? ~cur_bit : 1'b0;
      end
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load) |=> (txr == $past(txr)));

  assert_sda_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_in));

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  assert_release_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(fall)) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_byte_shifter.sv
module sim_i2c_byte_shifter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b0;
  logic peer_sda = 1'b1;
  logic load = 1'b0;
  logic [8:0] tx_word = '0;
  logic alt_map = 1'b0;
  logic phase_sel = 1'b0;
  logic sda_oe, busy, done;
  logic [8:0] rx_word;
  wire sda_bus = ~sda_oe & peer_sda;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_shifter u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .load(load),
    .tx_word(tx_word), .alt_map(alt_map), .phase_sel(phase_sel),
    .sda_oe(sda_oe), .busy(busy), .done(done), .rx_word(rx_word)
  );

  task automatic check(input logic ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] layout(input logic [7:0] d, input logic ack, input logic alt, input logic ph);
    if (alt && !ph) return {d[0], ack, d[7:1]};
    return {ack, d};
  endfunction

  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected done", rx_word, 9'h000);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(rx_word == e, "R6/R7/R8/R10 rx_word", rx_word, e);
      end
      check(!busy, "R9 busy low with done", {8'b0, busy}, 9'h000);
    end
    if (rst_n && done_prev) check(!done, "R9 done one cycle", {8'b0, done}, 9'h000);
    done_prev = done;
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [8:0] tx, input logic [7:0] peer, input logic peer_ack,
                      input logic alt, input logic ph, input logic inject);
    logic [8:0] bus;
    logic [7:0] d;
    int seen;
    for (int i = 0; i < 8; i++) bus[8-i] = tx[7-i] & peer[7-i];
    bus[0] = tx[8] & peer_ack;
    d = bus[8:1];
    exp_q.push_back(layout(d, bus[0], alt, ph));
    alt_map = alt;
    phase_sel = ph;
    @(negedge clk);
    tx_word = tx;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check(busy, "R2 load accepted", {8'b0, busy}, 9'h001);
    seen = done_seen;
    for (int i = 0; i < 9; i++) begin
      logic txb;
      txb = (i == 8) ? tx[8] : tx[7-i];
      peer_sda = (i == 8) ? peer_ack : peer[7-i];
      if (inject && i == 4) begin
        tx_word = ~tx;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        clocks(2);
      end else clocks(3);
      check(sda_oe == ~txb, (i == 8) ? "R4 ack drive" : "R3 data drive", {8'b0, sda_oe}, {8'b0, ~txb});
      scl = 1'b1;
      clocks(3);
      if (i == 8) check(done_seen == seen + 1, "R9 done after ninth rise", 9'(done_seen - seen), 9'h001);
      scl = 1'b0;
      clocks(3);
    end
    peer_sda = 1'b1;
    check(!sda_oe, "R4 release after ninth fall", {8'b0, sda_oe}, 9'h000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clocks(3);
    check(sda_oe == 0 && done == 0 && busy == 0, "R1 reset outputs", {6'b0, sda_oe, done, busy}, 9'h000);
    check(rx_word == 0, "R1 reset rx_word", rx_word, 9'h000);
    rst_n = 1'b1;
    clocks(2);
    xfer(9'h1A5, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    xfer(9'h03C, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    xfer(9'h0FF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    xfer(9'h1FF, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0);
    xfer(9'h0FF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
    xfer(9'h0FF, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0);
    xfer(9'h0FF, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b0);
    xfer(9'h0F0, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
    xfer(9'h0D2, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1);
    xfer(9'h1FF, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
    clocks(5);
    check(exp_q.size() == 0, "R9 all results seen", 9'(exp_q.size()), 9'h000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule